// File: doc/BRIEF.md
# Instruction Byte Prefetch Queue

This block sits between a 16-bit bus fetch engine and a consumer that decodes instructions one byte at a time. It keeps up to six instruction bytes in arrival order. Whenever at least two byte slots are free, no fetch is outstanding and the consumer is not asking for an operand bus cycle, it requests the next 16-bit word from a running fetch pointer. Each returned word adds its bytes to the tail of the queue. The consumer reads one byte per cycle from the head.

A redirect input models a taken branch. It empties the queue at once and reloads the fetch pointer with the target address. If a fetch is still on the bus when the redirect arrives, the data it later returns is thrown away. When the target is odd, the first word fetched after the redirect adds only its upper byte.

Operand accesses have priority over prefetching, but they never cut off a bus cycle that has already started. A grant is given only after any outstanding fetch has returned.

Top module: `prefetch_queue`

## Requirements
- R1: Bytes leave the queue in the order they entered, and the queue holds at most 6 bytes. Within a fetched word, the low byte `fetch_data_i[7:0]` (even address) enters before the high byte `fetch_data_i[15:8]`.
- R2: `fetch_req_o` is high only when at least two slots are free, `op_req_i` is low, `flush_i` is low and no fetch is outstanding. A fetch becomes outstanding at the edge where `fetch_req_o` is high, and stays outstanding until the edge where `fetch_valid_i` is high.
- R3: `fetch_addr_o` is always even. After each accepted word the fetch pointer advances to the next even address, which is 2 higher.
- R4: When `rd_en_i` is high at an edge and the queue is not empty, the byte at the head is removed. `rd_data_o` shows the head byte whenever `rd_valid_o` is high, and `rd_valid_o` is low when the queue is empty. A read of an empty queue changes nothing.
- R5: `op_grant_o` is high only while `op_req_i` is high and no fetch is outstanding. A request made during a fetch is granted in the cycle after that fetch's `fetch_valid_i` edge.
- R6: When `flush_i` is high at an edge, the queue is empty after that edge. The next fetch then uses the even address at or below `flush_addr_i`.
- R7: If a fetch is outstanding when `flush_i` arrives, its returned word enqueues nothing. A returned word that arrives in the same cycle as `flush_i` is also discarded.
- R8: If the redirect target is odd, the first accepted word after it enqueues only `fetch_data_i[15:8]`.
- R9: With five or six bytes queued, `fetch_req_o` stays low and the bus stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Branch redirect: empty the queue and reload the fetch pointer |
| flush_addr_i | input | ADDR_W | Branch target byte address |
| fetch_req_o | output | 1 | Request a 16-bit instruction fetch |
| fetch_addr_o | output | ADDR_W | Even byte address of the requested word |
| fetch_valid_i | input | 1 | The outstanding fetch returns data this cycle |
| fetch_data_i | input | 16 | Returned word, with the low byte at the even address |
| op_req_i | input | 1 | Consumer requests an operand bus cycle |
| op_grant_o | output | 1 | The operand cycle may start |
| rd_en_i | input | 1 | Remove the head byte |
| rd_data_o | output | 8 | Head byte |
| rd_valid_o | output | 1 | The queue is not empty |

## Verification
A wrong write index or count shows up on `rd_data_o` as a byte out of order or repeated, at the very read where the bad slot reaches the head. A fill level that is off by one shows up at once as `fetch_req_o` high with only one slot free, or low with two slots free. A lost outstanding flag shows up in the same cycle as `op_grant_o` high during a fetch, or as a second request before the first has returned. A missed discard shows up in the cycle after the stale word returns, as `rd_valid_o` going high after a redirect.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned WORD_W   = 16;
    localparam int unsigned WORD_BYT = WORD_W / BYTE_W;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [1:0]        wr_cnt_t;   // 0, 1 or 2 bytes per write
endpackage

// File: rtl/pfq_store.sv
module pfq_store
    import pfq_pkg::*;
#(
    parameter int unsigned DEPTH = 6,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  wr_cnt_t       wr_cnt_i,
    input  byte_t         wr_b0_i,
    input  byte_t         wr_b1_i,
    input  logic          rd_i,
    output byte_t         head_o,
    output logic [CW-1:0] count_o
);
    localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] mem;
        logic [IW-1:0]                rd_idx;
        logic [CW-1:0]                count;
    } st_t;

    st_t s_d, s_q;

    function automatic logic [IW-1:0] nxt(input logic [IW-1:0] i);
        return (i == IW'(DEPTH - 1)) ? '0 : i + IW'(1);
    endfunction

    always_comb begin
        logic [CW:0]   sum;
        logic [IW-1:0] w_idx;
        logic          pop;
        s_d   = s_q;
        pop   = rd_i && (s_q.count != '0);
        sum   = (CW+1)'(s_q.rd_idx) + (CW+1)'(s_q.count);
        if (sum >= (CW+1)'(DEPTH)) sum = sum - (CW+1)'(DEPTH);
        w_idx = IW'(sum);
        if (clr_i) begin
            s_d.rd_idx = '0;
            s_d.count  = '0;
        end else begin
            if (wr_cnt_i != 2'd0) s_d.mem[w_idx]      = wr_b0_i;
            if (wr_cnt_i == 2'd2) s_d.mem[nxt(w_idx)] = wr_b1_i;
            if (pop) s_d.rd_idx = nxt(s_q.rd_idx);
            s_d.count = s_q.count + CW'(wr_cnt_i) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head_o  = s_q.mem[s_q.rd_idx];
    assign count_o = s_q.count;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && wr_cnt_i != 2'd0) |-> ((CW+1)'(s_q.count) + (CW+1)'(wr_cnt_i) <= (CW+1)'(DEPTH))); // R1
endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch
    import pfq_pkg::*;
#(
    parameter int unsigned DEPTH  = 6,
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] flush_addr_i,
    input  logic              fetch_valid_i,
    input  logic [WORD_W-1:0] fetch_data_i,
    input  logic              op_req_i,
    input  logic [CW-1:0]     count_i,
    output logic              fetch_req_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              op_grant_o,
    output wr_cnt_t           wr_cnt_o,
    output byte_t             wr_b0_o,
    output byte_t             wr_b1_o,
    output logic              clr_o
);
    localparam logic [CW-1:0] REQ_MAX = CW'(DEPTH - WORD_BYT);

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              busy;
        logic              drop;
    } st_t;

    st_t s_d, s_q;
    logic accept;

    assign fetch_req_o  = !s_q.busy && !op_req_i && !flush_i && (count_i <= REQ_MAX);
    assign fetch_addr_o = {s_q.ptr[ADDR_W-1:1], 1'b0};
    assign op_grant_o   = op_req_i && !s_q.busy;
    assign accept       = s_q.busy && fetch_valid_i && !s_q.drop && !flush_i;
    assign clr_o        = flush_i;

    always_comb begin
        s_d      = s_q;
        wr_cnt_o = 2'd0;
        wr_b0_o  = fetch_data_i[7:0];
        wr_b1_o  = fetch_data_i[15:8];
        if (accept) begin
            if (s_q.ptr[0]) begin
                wr_cnt_o = 2'd1;
                wr_b0_o  = fetch_data_i[15:8];
            end else begin
                wr_cnt_o = 2'd2;
            end
        end
        if (flush_i) begin
            s_d.ptr  = flush_addr_i;
            s_d.busy = s_q.busy && !fetch_valid_i;
            s_d.drop = s_q.busy && !fetch_valid_i;
        end else begin
            if (s_q.busy && fetch_valid_i) begin
                s_d.busy = 1'b0;
                s_d.drop = 1'b0;
                if (!s_q.drop)
                    s_d.ptr = {s_q.ptr[ADDR_W-1:1] + (ADDR_W-1)'(1), 1'b0};
            end
            if (fetch_req_o) s_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o |=> !fetch_req_o); // R2
    AST_OP_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_req_o && op_grant_o)); // R5
    AST_DROP_STALE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.drop && fetch_valid_i) |-> (wr_cnt_o == 2'd0)); // R7
    AST_IDLE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (count_i > REQ_MAX) |-> !fetch_req_o); // R9
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
    import pfq_pkg::*;
#(
    parameter int unsigned DEPTH  = 6,
    parameter int unsigned ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] flush_addr_i,
    output logic              fetch_req_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    input  logic              fetch_valid_i,
    input  logic [15:0]       fetch_data_i,
    input  logic              op_req_i,
    output logic              op_grant_o,
    input  logic              rd_en_i,
    output logic [7:0]        rd_data_o,
    output logic              rd_valid_o
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [CW-1:0] count;
    wr_cnt_t       wr_cnt;
    byte_t         wr_b0, wr_b1;
    logic          clr;

    pfq_fetch #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CW(CW)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .flush_addr_i (flush_addr_i),
        .fetch_valid_i(fetch_valid_i),
        .fetch_data_i (fetch_data_i),
        .op_req_i     (op_req_i),
        .count_i      (count),
        .fetch_req_o  (fetch_req_o),
        .fetch_addr_o (fetch_addr_o),
        .op_grant_o   (op_grant_o),
        .wr_cnt_o     (wr_cnt),
        .wr_b0_o      (wr_b0),
        .wr_b1_o      (wr_b1),
        .clr_o        (clr)
    );

    pfq_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .wr_cnt_i(wr_cnt),
        .wr_b0_i (wr_b0),
        .wr_b1_i (wr_b1),
        .rd_i    (rd_en_i),
        .head_o  (rd_data_o),
        .count_o (count)
    );

    assign rd_valid_o = (count != '0);

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !rd_valid_o); // R6
    AST_FETCH_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o |-> !fetch_addr_o[0]); // R3
endmodule

// File: tb/test_prefetch_queue.sv
module test_prefetch_queue;
    localparam int unsigned AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush_i = 1'b0;
    logic [AW-1:0] flush_addr_i = '0;
    logic          fetch_req_o;
    logic [AW-1:0] fetch_addr_o;
    logic          fetch_valid_i = 1'b0;
    logic [15:0]   fetch_data_i = '0;
    logic          op_req_i = 1'b1;
    logic          op_grant_o;
    logic          rd_en_i = 1'b0;
    logic [7:0]    rd_data_o;
    logic          rd_valid_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    prefetch_queue #(.DEPTH(6), .ADDR_W(AW)) i_prefetch_queue (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
        .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
        .fetch_valid_i(fetch_valid_i), .fetch_data_i(fetch_data_i),
        .op_req_i(op_req_i), .op_grant_o(op_grant_o),
        .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
    );

    function automatic logic [7:0] bval(input logic [AW-1:0] a);
        return (a[7:0] ^ {a[11:8], a[11:8]}) + 8'h3C;
    endfunction

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    // at a negedge: wait for a request, check its address, return one word
    task automatic serve(input logic [AW-1:0] exp_addr, input logic block_after);
        int n = 0;
        op_req_i = 1'b0;
        #1;
        while (!fetch_req_o && n < 20) begin
            @(negedge clk); #1; n++;
        end
        chk("R3 fetch address", 32'(fetch_addr_o), 32'(exp_addr));
        @(posedge clk);
        @(negedge clk);
        fetch_valid_i = 1'b1;
        fetch_data_i  = {bval(exp_addr + 1), bval(exp_addr)};
        @(posedge clk);
        @(negedge clk);
        fetch_valid_i = 1'b0;
        op_req_i = block_after;
        #1;
    endtask

    task automatic pop_check(input string r, input logic [7:0] exp);
        chk({r, " valid"}, 32'(rd_valid_o), 1);
        chk({r, " data"}, 32'(rd_data_o), 32'(exp));
        rd_en_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en_i = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        #1;
        chk("R4 reset empty", 32'(rd_valid_o), 0);
        chk("R5 reset grant with idle bus", 32'(op_grant_o), 1);
        op_req_i = 1'b0; #1;
        chk("R2 reset request", 32'(fetch_req_o), 1);
        chk("R3 reset address", 32'(fetch_addr_o), 0);
        op_req_i = 1'b1; #1;
    endtask

    task automatic t_fill_order;
        serve(20'h0, 1'b0);
        chk("R2 request with four free", 32'(fetch_req_o), 1);
        serve(20'h2, 1'b0);
        chk("R2 request with two free", 32'(fetch_req_o), 1);
        serve(20'h4, 1'b0);
        chk("R9 idle when full", 32'(fetch_req_o), 0);
        pop_check("R1 byte 0", bval(20'h0));
        chk("R9 idle with five queued", 32'(fetch_req_o), 0);
        pop_check("R1 byte 1", bval(20'h1));
        chk("R2 request after two freed", 32'(fetch_req_o), 1);
        serve(20'h6, 1'b1);
        for (int i = 2; i < 8; i++) pop_check("R1 in-order drain", bval(AW'(i)));
        chk("R4 empty after drain", 32'(rd_valid_o), 0);
    endtask

    task automatic t_empty_read;
        rd_en_i = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_en_i = 1'b0; #1;
        chk("R4 empty read keeps empty", 32'(rd_valid_o), 0);
        serve(20'h8, 1'b1);
        pop_check("R4 after empty read b0", bval(20'h8));
        pop_check("R4 after empty read b1", bval(20'h9));
        chk("R4 empty again", 32'(rd_valid_o), 0);
    endtask

    task automatic t_op_priority;
        op_req_i = 1'b0; #1;
        chk("R2 request before operand", 32'(fetch_req_o), 1);
        @(posedge clk); @(negedge clk);
        op_req_i = 1'b1; #1;
        chk("R5 no grant during fetch", 32'(op_grant_o), 0);
        chk("R2 no request during fetch", 32'(fetch_req_o), 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk("R5 operand still waiting", 32'(op_grant_o), 0);
        end
        fetch_valid_i = 1'b1;
        fetch_data_i  = {bval(20'hB), bval(20'hA)};
        @(posedge clk); @(negedge clk);
        fetch_valid_i = 1'b0; #1;
        chk("R5 grant after fetch completes", 32'(op_grant_o), 1);
        chk("R2 no prefetch under operand", 32'(fetch_req_o), 0);
        pop_check("R5 fetched byte kept b0", bval(20'hA));
        pop_check("R5 fetched byte kept b1", bval(20'hB));
    endtask

    task automatic t_flush_inflight;
        op_req_i = 1'b0; #1;
        chk("R3 next address", 32'(fetch_addr_o), 32'h0C);
        @(posedge clk); @(negedge clk);
        flush_i = 1'b1; flush_addr_i = 20'h100; #1;
        chk("R2 no request during flush", 32'(fetch_req_o), 0);
        @(posedge clk); @(negedge clk);
        flush_i = 1'b0; #1;
        chk("R6 empty after flush", 32'(rd_valid_o), 0);
        chk("R7 stale fetch still outstanding", 32'(fetch_req_o), 0);
        fetch_valid_i = 1'b1;
        fetch_data_i  = {bval(20'hD), bval(20'hC)};
        @(posedge clk); @(negedge clk);
        fetch_valid_i = 1'b0; #1;
        chk("R7 stale word discarded", 32'(rd_valid_o), 0);
        serve(20'h100, 1'b1);
        pop_check("R6 target byte 0", bval(20'h100));
        pop_check("R6 target byte 1", bval(20'h101));
    endtask

    task automatic t_flush_odd;
        serve(20'h102, 1'b1);
        chk("R6 queue holds data before flush", 32'(rd_valid_o), 1);
        flush_i = 1'b1; flush_addr_i = 20'h203;
        @(posedge clk); @(negedge clk);
        flush_i = 1'b0; #1;
        chk("R6 flush empties queued bytes", 32'(rd_valid_o), 0);
        serve(20'h202, 1'b1);
        pop_check("R8 odd target upper byte", bval(20'h203));
        chk("R8 only one byte enqueued", 32'(rd_valid_o), 0);
        serve(20'h204, 1'b1);
        pop_check("R3 step after odd b0", bval(20'h204));
        pop_check("R3 step after odd b1", bval(20'h205));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_order();
        t_empty_read();
        t_op_priority();
        t_flush_inflight();
        t_flush_odd();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule